// File: doc/BRIEF.md
# Incremental Quadrature Output Generator

This block turns a stream of interpolation step requests, each tagged with a direction of motion, into the classic incremental encoder outputs. It produces two quadrature channels, a combined edge channel that toggles once per step, and a zero marker that is active once per signal cycle. The number of steps that make up one signal cycle is set by a resolution input. The zero marker can be placed on any of eight 45-degree sector boundaries within the cycle.

Requests can arrive faster than the outputs may move, because an output change needs two clocks. Pending steps therefore wait in a small signed backlog, and the outputs drain it one step at a time. When the backlog would grow past its limit, an overspeed condition is latched until reset. This condition drives an active-low error output, which an enable input can mask.

Top module: `quad_step_emitter`

## Requirements
- R1: After reset, ax_o, bx_o and axb_o are 0 and err_no is 1. zx_o is 1 exactly when zero_sel_i is 0.
- R2: Forward steps walk the step index upward. (ax_o, bx_o) follows the index modulo 4 as 0:(0,0), 1:(1,0), 2:(1,1), 3:(0,1), so A leads B.
- R3: Reverse steps walk the index downward through the same table, so B leads A.
- R4: Each delivered step toggles exactly one of ax_o and bx_o. axb_o equals ax_o xor bx_o and toggles once per step.
- R5: The index wraps between steps_per_cyc_i-1 and 0. With steps_per_cyc_i = 8, one full cycle gives 8 axb_o edges and 2 rising edges of ax_o.
- R6: Two output changes are always at least two clocks apart. A lone request sampled at one clock edge reaches the outputs at the next edge.
- R7: Requests in consecutive cycles are all delivered, in order, through a signed backlog. A forward request followed by a reverse request leaves the index where it started.
- R8: zx_o is 1 exactly while the step index equals zero_sel_i * (steps_per_cyc_i / 8). steps_per_cyc_i is a multiple of 8.
- R9: A request that would push the backlog magnitude past 2**(BL_W-1)-1 latches an overspeed flag. The flag drives err_no low while err_en_i is 1, stays set, and clears only on reset.
- R10: While err_en_i is 0, err_no is 1 whatever the overspeed flag holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| step_req_i | input | 1 | One interpolation step requested this cycle |
| step_fwd_i | input | 1 | Direction of the request: 1 forward, 0 reverse |
| steps_per_cyc_i | input | POS_W | Steps per signal cycle, a multiple of 8 |
| zero_sel_i | input | 3 | 45-degree sector boundary that carries the zero marker |
| err_en_i | input | 1 | Enables the overspeed error output |
| ax_o | output | 1 | Quadrature channel A |
| bx_o | output | 1 | Quadrature channel B |
| axb_o | output | 1 | A xor B, one edge per step |
| zx_o | output | 1 | Zero marker |
| err_no | output | 1 | Overspeed error, active low |

## Verification
The hardest case to reach from the ports is a backlog that actually hits its limit. Because one step drains every other clock, the backlog only climbs when requests stay back-to-back for many cycles. The bench therefore holds the request high for thirty cycles to force the overflow, and first shows that a six-cycle burst stays under the limit and is delivered in full. A full sweep of every sector against every index, at two resolutions and in both directions, covers the zero-marker placement and the wrap in each direction.

// File: rtl/qg_pkg.sv
package qg_pkg;
  // quadrature levels for the low two bits of the step index
  function automatic logic quad_a(input logic [1:0] idx);
    return idx[1] ^ idx[0];
  endfunction
  function automatic logic quad_b(input logic [1:0] idx);
    return idx[1];
  endfunction
endpackage

// File: rtl/qg_backlog.sv
module qg_backlog #(
  parameter int BL_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   fwd_i,
  output logic                   emit_o,
  output logic                   emit_fwd_o,
  output logic                   ovf_o,
  output logic signed [BL_W-1:0] bl_o
);
  localparam int LIM = 2**(BL_W-1) - 1;
  localparam logic signed [BL_W+1:0] LIM_P = (BL_W+2)'(LIM);
  localparam logic signed [BL_W+1:0] LIM_N = -LIM_P;
  localparam logic signed [BL_W+1:0] P1    = (BL_W+2)'(1);
  localparam logic signed [BL_W+1:0] M1    = -P1;

  logic signed [BL_W-1:0] bl_q, bl_d;
  logic                   gap_q, gap_d;
  logic signed [BL_W+1:0] bl_ext, in_v, out_v, sum;

  always_comb begin
    emit_o     = (bl_q != '0) && !gap_q;
    emit_fwd_o = !bl_q[BL_W-1];
    bl_ext     = {{2{bl_q[BL_W-1]}}, bl_q};
    in_v       = req_i ? (fwd_i ? P1 : M1) : '0;
    out_v      = emit_o ? (emit_fwd_o ? P1 : M1) : '0;
    sum        = bl_ext + in_v - out_v;
    ovf_o      = (sum > LIM_P) || (sum < LIM_N);
    if (sum > LIM_P)      bl_d = LIM_P[BL_W-1:0];
    else if (sum < LIM_N) bl_d = LIM_N[BL_W-1:0];
    else                  bl_d = sum[BL_W-1:0];
    gap_d      = emit_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q  <= '0;
      gap_q <= 1'b0;
    end else begin
      bl_q  <= bl_d;
      gap_q <= gap_d;
    end
  end

  assign bl_o = bl_q;
endmodule

// File: rtl/qg_position.sv
module qg_position #(
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic             fwd_i,
  input  logic [POS_W-1:0] steps_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q, pos_d, last;

  always_comb begin
    last  = steps_i - 1'b1;
    pos_d = pos_q;
    if (emit_i) begin
      if (fwd_i) pos_d = (pos_q == last) ? '0 : pos_q + 1'b1;
      else       pos_d = (pos_q == '0) ? last : pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (emit_i) pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/qg_zero_decode.sv
module qg_zero_decode #(
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] steps_i,
  input  logic [2:0]       sel_i,
  output logic             zx_o
);
  logic [POS_W+2:0] mark;

  always_comb begin
    mark = {{POS_W{1'b0}}, sel_i} * {3'b000, (steps_i >> 3)};
    zx_o = (mark == {3'b000, pos_i});
  end
endmodule

// File: rtl/quad_step_emitter.sv
module quad_step_emitter #(
  parameter int POS_W = 8,
  parameter int BL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_req_i,
  input  logic             step_fwd_i,
  input  logic [POS_W-1:0] steps_per_cyc_i,
  input  logic [2:0]       zero_sel_i,
  input  logic             err_en_i,
  output logic             ax_o,
  output logic             bx_o,
  output logic             axb_o,
  output logic             zx_o,
  output logic             err_no
);
  import qg_pkg::*;

  logic [1:0]             rsync_q;
  logic                   rst_s;
  logic                   emit, emit_fwd, ovf;
  logic signed [BL_W-1:0] bl_w;
  logic [POS_W-1:0]       pos;
  logic                   err_q, err_d;

  // reset asserted at once, released after two clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  qg_backlog #(.BL_W(BL_W)) u_backlog (
    .clk_i(clk_i), .rst_ni(rst_s), .req_i(step_req_i), .fwd_i(step_fwd_i),
    .emit_o(emit), .emit_fwd_o(emit_fwd), .ovf_o(ovf), .bl_o(bl_w)
  );

  qg_position #(.POS_W(POS_W)) u_position (
    .clk_i(clk_i), .rst_ni(rst_s), .emit_i(emit), .fwd_i(emit_fwd),
    .steps_i(steps_per_cyc_i), .pos_o(pos)
  );

  qg_zero_decode #(.POS_W(POS_W)) u_zero (
    .pos_i(pos), .steps_i(steps_per_cyc_i), .sel_i(zero_sel_i), .zx_o(zx_o)
  );

  always_comb err_d = err_q | ovf;

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign ax_o   = quad_a(pos[1:0]);
  assign bx_o   = quad_b(pos[1:0]);
  assign axb_o  = pos[0];
  assign err_no = !(err_q && err_en_i);
endmodule

// File: rtl/qg_checker.sv
module qg_checker #(
  parameter int POS_W = 8,
  parameter int BL_W  = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ax_o,
  input logic                   bx_o,
  input logic                   axb_o,
  input logic                   zx_o,
  input logic                   err_no,
  input logic                   err_en_i,
  input logic [2:0]             zero_sel_i,
  input logic [POS_W-1:0]       steps_per_cyc_i,
  input logic signed [BL_W-1:0] bl_i
);
  p_one_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ax_o ^ $past(ax_o), bx_o ^ $past(bx_o)}) <= 1);

  p_axb_xor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    axb_o == (ax_o ^ bx_o));

  p_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (axb_o != $past(axb_o)) |=> (axb_o == $past(axb_o)));

  p_backlog_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (axb_o != $past(axb_o)) |-> ($past(bl_i) != '0));

  p_zx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(axb_o) && $stable(ax_o) && $stable(zero_sel_i) && $stable(steps_per_cyc_i))
      |-> $stable(zx_o));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_no) |=> (!err_no || !err_en_i));

  p_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_en_i) |-> err_no);
endmodule

bind quad_step_emitter qg_checker #(.POS_W(POS_W), .BL_W(BL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ax_o(ax_o), .bx_o(bx_o), .axb_o(axb_o),
  .zx_o(zx_o), .err_no(err_no), .err_en_i(err_en_i), .zero_sel_i(zero_sel_i),
  .steps_per_cyc_i(steps_per_cyc_i), .bl_i(bl_w)
);

// File: tb/quad_step_emitter_tb.sv
module quad_step_emitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W = 8;

  logic clk = 1'b0;
  logic rst_n, req, fwd, en;
  logic [POS_W-1:0] steps;
  logic [2:0] zsel;
  logic ax, bx, axb, zx, errn;

  int nchk = 0, nfail = 0;
  int model_pos = 0;
  int axb_edges = 0, ax_rises = 0, since = 9, spacing_bad = 0;
  logic prev_axb = 1'b0, prev_ax = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_step_emitter #(.POS_W(POS_W), .BL_W(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_req_i(req), .step_fwd_i(fwd),
    .steps_per_cyc_i(steps), .zero_sel_i(zsel), .err_en_i(en),
    .ax_o(ax), .bx_o(bx), .axb_o(axb), .zx_o(zx), .err_no(errn)
  );

  // edge monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (axb !== prev_axb) begin
        axb_edges++;
        if (since < 2) spacing_bad++;
        since = 1;
      end else if (since < 9) since++;
      if (ax === 1'b1 && prev_ax === 1'b0) ax_rises++;
    end
    prev_axb = axb;
    prev_ax  = ax;
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_pos = 0;
  endtask

  function automatic int exp_zx(int p);
    return (p == int'(zsel) * (int'(steps) / 8)) ? 1 : 0;
  endfunction

  task automatic check_outputs(input string rq);
    chk(rq, "ax", int'(ax), ((model_pos >> 1) ^ model_pos) & 1);
    chk(rq, "bx", int'(bx), (model_pos >> 1) & 1);
    chk("R4", "axb", int'(axb), model_pos & 1);
    chk("R8", "zx", int'(zx), exp_zx(model_pos));
  endtask

  task automatic do_step(input bit f);
    @(negedge clk); req = 1'b1; fwd = f;
    @(negedge clk); req = 1'b0;
    repeat (3) @(negedge clk);
    if (f) model_pos = (model_pos + 1) % int'(steps);
    else   model_pos = (model_pos + int'(steps) - 1) % int'(steps);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    fwd = 1'b1; en = 1'b1; steps = 8'd16; zsel = 3'd0; req = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1", "ax", int'(ax), 0);
    chk("R1", "bx", int'(bx), 0);
    chk("R1", "axb", int'(axb), 0);
    chk("R1", "errn", int'(errn), 1);
    chk("R1", "zx", int'(zx), 1);

    // R6 latency: request sampled at one edge, outputs move at the next
    @(negedge clk); req = 1'b1; fwd = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R6", "axb before", int'(axb), 0);
    @(negedge clk);
    chk("R6", "axb after", int'(axb), 1);
    repeat (3) @(negedge clk);
    model_pos = 1;
    check_outputs("R2");
    do_reset();

    // R2 R3 R5 R8 sweep over resolution, sector and direction
    for (int r = 0; r < 2; r++) begin
      steps = (r == 0) ? 8'd8 : 8'd16;
      for (int s = 0; s < 8; s++) begin
        zsel = 3'(s);
        do_reset();
        check_outputs("R8");
        axb_edges = 0; ax_rises = 0;
        for (int k = 0; k < int'(steps); k++) begin
          do_step(1'b1);
          check_outputs("R2");
        end
        chk("R5", "wrap fwd", model_pos, 0);
        if (r == 0) begin
          chk("R5", "axb edges per cycle", axb_edges, 8);
          chk("R5", "ax rises per cycle", ax_rises, 2);
        end
        for (int k = 0; k < int'(steps); k++) begin
          do_step(1'b0);
          check_outputs("R3");
        end
      end
    end

    // R7 burst of back-to-back requests
    steps = 8'd16; zsel = 3'd2;
    do_reset();
    @(negedge clk); req = 1'b1; fwd = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    repeat (12) @(negedge clk);
    model_pos = 3;
    check_outputs("R7");

    // R7 forward then reverse returns to start with two edges
    axb_edges = 0;
    @(negedge clk); req = 1'b1; fwd = 1'b1;
    @(negedge clk); fwd = 1'b0;
    @(negedge clk); req = 1'b0;
    repeat (12) @(negedge clk);
    check_outputs("R7");
    chk("R7", "cancel edges", axb_edges, 2);

    // R9 a burst of six stays below the limit and is fully delivered
    en = 1'b1;
    do_reset();
    @(negedge clk); req = 1'b1; fwd = 1'b1;
    repeat (6) @(negedge clk);
    req = 1'b0;
    repeat (16) @(negedge clk);
    chk("R9", "no error on short burst", int'(errn), 1);
    model_pos = 6;
    check_outputs("R7");

    // R9 a long burst overflows the backlog, error is sticky
    @(negedge clk); req = 1'b1; fwd = 1'b0;
    repeat (30) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk("R9", "error on overflow", int'(errn), 0);
    repeat (40) @(negedge clk);
    chk("R9", "error sticky", int'(errn), 0);
    // R10 mask
    en = 1'b0;
    @(negedge clk);
    chk("R10", "masked", int'(errn), 1);
    en = 1'b1;
    @(negedge clk);
    chk("R9", "unmasked still latched", int'(errn), 0);
    do_reset();
    chk("R9", "cleared by reset", int'(errn), 1);

    chk("R6", "edge spacing violations", spacing_bad, 0);
    summary();
  end
endmodule